// File: doc/BRIEF.md
# CAN Error and Status Word with Warning Flags

This block assembles the 32-bit error and status word of a CAN controller and keeps the latched interrupt flags that belong to it. The protocol engine, the bit-timing logic and the two error counters sit outside. Their values arrive here as plain inputs: the transmit and receive error counts, the bus synchronisation, bus-off and freeze conditions, six error-kind indications, bus activity and fault-confinement state, and single-cycle event pulses for bus-off, error and wake-up.

Two warning flags record the moment that either error counter first climbs to the warning limit of 96. The level compare is combinational. Each flag latches on the rising edge of that compare, as seen against a registered copy of the previous compare result. A global warning enable hides both flags and stops them from setting. The transmit flag cannot set while the controller is bus-off. Freeze mode holds both flags exactly as they are. Three further event flags latch their pulses.

All five flags clear through a write-one-to-clear access on a single-cycle register write port. Each flag drives one interrupt line through its own mask bit.

Top module: `can_err_status`

## Requirements
- R1: Bits 31 to 19 of `stat_word` always read 0, including after a write of all ones.
- R2: Bit 18 follows `sync_ok` in the same cycle. Bits 15..10 follow `err_bits[5:0]`. Bit 7 is `idle_st`, bit 6 is `tx_busy`, bits 5..4 are `fault_st`, and bit 3 is `rx_busy`. None of these bits is latched.
- R3: Bit 9 is 1 exactly when `tx_err_cnt` >= 96, and bit 8 is 1 exactly when `rx_err_cnt` >= 96, both in the same cycle.
- R4: Bit 17 (transmit warning flag) sets one clock after bit 9 goes from 0 to 1. Bit 16 (receive warning flag) does the same for bit 8. A counter that stays at or above 96 does not set a cleared flag again.
- R5: Writing 1 to bit 17, 16, 2, 1 or 0 clears that flag at the write clock. Writing 0 to a bit leaves it unchanged.
- R6: While `warn_en` is 0, bits 17 and 16 and irq[4:3] read 0, and no crossing sets a warning flag. A flag already set before the disable reappears when `warn_en` returns to 1.
- R7: While `bus_off` is 1, a transmit crossing does not set bit 17. A receive crossing still sets bit 16.
- R8: While `freeze` is 1, bits 17 and 16 neither set nor clear.
- R9: A pulse on `int_evt[2]`, `int_evt[1]` or `int_evt[0]` sets bit 2 (bus-off), bit 1 (error) or bit 0 (wake-up) respectively, one clock later.
- R10: When a set condition and a write-one-to-clear reach the same flag at the same clock, the flag ends up set.
- R11: irq[4] is the visible bit 17 ANDed with int_mask[4]. irq[3] pairs bit 16 with int_mask[3], irq[2] pairs bit 2 with int_mask[2], irq[1] pairs bit 1 with int_mask[1], and irq[0] pairs bit 0 with int_mask[0].
- R12: A clock with `rst_n` low clears all five flags and the stored compare history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_err_cnt | input | CNT_W | Transmit error counter value |
| rx_err_cnt | input | CNT_W | Receive error counter value |
| sync_ok | input | 1 | Engine is synchronised to the bus |
| bus_off | input | 1 | Controller is in the bus-off state |
| freeze | input | 1 | Freeze mode; holds the warning flags |
| warn_en | input | 1 | Global warning enable |
| err_bits | input | 6 | Bit-1, bit-0, ack, CRC, form and stuff error status, MSB first |
| idle_st | input | 1 | Bus idle |
| tx_busy | input | 1 | Transmitting |
| rx_busy | input | 1 | Receiving |
| fault_st | input | 2 | Fault-confinement state |
| int_evt | input | 3 | Event pulses: [2] bus-off, [1] error, [0] wake-up |
| int_mask | input | 5 | Interrupt masks in irq order |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; a 1 clears the matching flag |
| stat_word | output | 32 | Packed status word |
| irq | output | 5 | Interrupt lines: [4] tx warn, [3] rx warn, [2] bus-off, [1] error, [0] wake-up |

## Verification
The stored state is small: one previous-compare bit per counter and five flag bits. A wrong flag is visible in `stat_word` and on `irq` one clock after the stimulus that should have moved it. A wrong compare-history bit shows up differently. It either produces a spurious warning one clock after the counter settles above the limit, or it swallows a genuine crossing. The bench therefore sweeps every start and end value pair across the limit and checks the flag at the first clock after each move.

// File: rtl/can_err_pkg.sv
// Shared constants for the CAN error/status word: field positions and counts.
// Assumes a 32-bit status word with the flag positions fixed by software decode.
package can_err_pkg;
    localparam int unsigned STAT_W    = 32;
    localparam int unsigned N_EVT     = 3;
    localparam int unsigned N_IRQ     = 5;
    localparam int unsigned N_DIR     = 2;
    localparam int unsigned ERR_W     = 6;
    // field positions inside the status word
    localparam int unsigned P_SYNC    = 18;
    localparam int unsigned P_TXW_F   = 17;
    localparam int unsigned P_RXW_F   = 16;
    localparam int unsigned P_ERR_LO  = 10;
    localparam int unsigned P_TXW_LVL = 9;
    localparam int unsigned P_RXW_LVL = 8;
    localparam int unsigned P_IDLE    = 7;
    localparam int unsigned P_TXBUSY  = 6;
    localparam int unsigned P_FLT_LO  = 4;
    localparam int unsigned P_RXBUSY  = 3;
    localparam int unsigned P_RSV_LO  = 19;
    // interrupt line order
    localparam int unsigned IRQ_TXW   = 4;
    localparam int unsigned IRQ_RXW   = 3;
    // direction index
    localparam int unsigned DIR_TX    = 0;
    localparam int unsigned DIR_RX    = 1;
endpackage

// File: rtl/can_warn_flag.sv
// One warning-limit detector with its latched interrupt flag.
// Assumes cnt is a stable registered counter value; the limit fits in CNT_W bits.
// Set on a rising crossing of the limit, gated by enable, freeze and (optionally) bus-off.
module can_warn_flag #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned WARN_LIM  = 96,
    parameter bit          GATE_BOFF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             warn_en,
    input  logic             bus_off,
    input  logic             freeze,
    input  logic             clr,
    output logic             level,
    output logic             flag
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(WARN_LIM);

    logic prev_lvl;
    logic set_req;
    logic boff_blk;

    // level compare against the warning limit
    assign level    = (cnt >= LIM);
    assign boff_blk = GATE_BOFF & bus_off;
    // rising crossing, only when enabled and allowed
    assign set_req  = level & ~prev_lvl & warn_en & ~freeze & ~boff_blk;

    // history of the compare result for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= level;
    end

    // flag: frozen in freeze mode, set beats clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (freeze)  flag <= flag;
        else if (set_req) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end
endmodule

// File: rtl/can_evt_flag.sv
// Sticky event flag with write-one-to-clear; a same-cycle set wins.
// Assumes set is a one-cycle pulse synchronous to clk.
module can_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // latch the event, clear on request unless a new event arrives
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/can_err_status.sv
// CAN error/status word with warning and event interrupt flags.
// Assumes all inputs are synchronous to clk; the register port is a one-cycle
// write strobe and the status word is always readable.
module can_err_status
    import can_err_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned WARN_LIM = 96
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    tx_err_cnt,
    input  logic [CNT_W-1:0]    rx_err_cnt,
    input  logic                sync_ok,
    input  logic                bus_off,
    input  logic                freeze,
    input  logic                warn_en,
    input  logic [5:0]          err_bits,
    input  logic                idle_st,
    input  logic                tx_busy,
    input  logic                rx_busy,
    input  logic [1:0]          fault_st,
    input  logic [2:0]          int_evt,
    input  logic [4:0]          int_mask,
    input  logic                reg_wr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         stat_word,
    output logic [4:0]          irq
);
    logic [CNT_W-1:0] cnt_dir  [N_DIR];
    logic [N_DIR-1:0] lvl_dir;
    logic [N_DIR-1:0] wflag;
    logic [N_DIR-1:0] wclr;
    logic [N_EVT-1:0] eflag;
    logic [N_EVT-1:0] eclr;
    logic [N_DIR-1:0] wvis;

    assign cnt_dir[DIR_TX] = tx_err_cnt;
    assign cnt_dir[DIR_RX] = rx_err_cnt;
    assign wclr[DIR_TX]    = reg_wr & reg_wdata[P_TXW_F];
    assign wclr[DIR_RX]    = reg_wr & reg_wdata[P_RXW_F];
    assign eclr            = {N_EVT{reg_wr}} & reg_wdata[N_EVT-1:0];

    // one warning detector per direction; only transmit is blocked by bus-off
    for (genvar d = 0; d < N_DIR; d++) begin : g_warn
        can_warn_flag #(
            .CNT_W     (CNT_W),
            .WARN_LIM  (WARN_LIM),
            .GATE_BOFF (d == DIR_TX)
        ) i_warn (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt_dir[d]),
            .warn_en (warn_en),
            .bus_off (bus_off),
            .freeze  (freeze),
            .clr     (wclr[d]),
            .level   (lvl_dir[d]),
            .flag    (wflag[d])
        );
    end

    // one sticky flag per event pulse
    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        can_evt_flag i_evt (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (int_evt[e]),
            .clr   (eclr[e]),
            .flag  (eflag[e])
        );
    end

    // warning flags are hidden while the warning enable is low
    assign wvis = wflag & {N_DIR{warn_en}};

    // pack the status word
    always_comb begin
        stat_word                             = '0;
        stat_word[P_SYNC]                     = sync_ok;
        stat_word[P_TXW_F]                    = wvis[DIR_TX];
        stat_word[P_RXW_F]                    = wvis[DIR_RX];
        stat_word[P_ERR_LO+ERR_W-1:P_ERR_LO]  = err_bits;
        stat_word[P_TXW_LVL]                  = lvl_dir[DIR_TX];
        stat_word[P_RXW_LVL]                  = lvl_dir[DIR_RX];
        stat_word[P_IDLE]                     = idle_st;
        stat_word[P_TXBUSY]                   = tx_busy;
        stat_word[P_FLT_LO+1:P_FLT_LO]        = fault_st;
        stat_word[P_RXBUSY]                   = rx_busy;
        stat_word[N_EVT-1:0]                  = eflag;
    end

    // masked interrupt lines
    assign irq = {wvis[DIR_TX], wvis[DIR_RX], eflag} & int_mask;
endmodule

// File: rtl/can_err_status_chk.sv
// Property checker for can_err_status, observing its ports only.
module can_err_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_off,
    input logic        freeze,
    input logic        warn_en,
    input logic [2:0]  int_evt,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] stat_word
);
    AST_TXW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[9] && !$past(stat_word[9]) && warn_en && !freeze && !bus_off)
        |=> (stat_word[17] || !warn_en)); // R4
    AST_RXW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[8] && !$past(stat_word[8]) && warn_en && !freeze)
        |=> (stat_word[16] || !warn_en)); // R4
    AST_TXW_BOFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat_word[17]) && $past(warn_en)) |-> !$past(bus_off)); // R7
    AST_WARN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(freeze) && $past(warn_en) && warn_en)
        |-> (stat_word[17:16] == $past(stat_word[17:16]))); // R8
    AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(int_evt[0]) |-> stat_word[0]); // R9
    AST_WAKE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && reg_wdata[0] && !int_evt[0]) |-> !stat_word[0]); // R5
endmodule

bind can_err_status can_err_status_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_off   (bus_off),
    .freeze    (freeze),
    .warn_en   (warn_en),
    .int_evt   (int_evt),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .stat_word (stat_word)
);

// File: tb/test_can_err_status.sv
// Self-checking bench for can_err_status: sweeps counters, crossings, masks.
module test_can_err_status;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  txc, rxc;
    logic        sync_ok, bus_off, freeze, warn_en;
    logic [5:0]  err_bits;
    logic        idle_st, tx_busy, rx_busy;
    logic [1:0]  fault_st;
    logic [2:0]  int_evt;
    logic [4:0]  int_mask;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] stat_word;
    logic [4:0]  irq;
    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    can_err_status i_can_err_status (
        .clk(clk), .rst_n(rst_n), .tx_err_cnt(txc), .rx_err_cnt(rxc),
        .sync_ok(sync_ok), .bus_off(bus_off), .freeze(freeze), .warn_en(warn_en),
        .err_bits(err_bits), .idle_st(idle_st), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .fault_st(fault_st), .int_evt(int_evt), .int_mask(int_mask),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .stat_word(stat_word), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected word; fl = {txw, rxw, boff, err, wake} as visible
    function automatic logic [31:0] expw(logic [4:0] fl);
        logic [31:0] w = '0;
        w[18]    = sync_ok;
        w[17]    = fl[4];
        w[16]    = fl[3];
        w[15:10] = err_bits;
        w[9]     = (txc >= 8'd96);
        w[8]     = (rxc >= 8'd96);
        w[7]     = idle_st;
        w[6]     = tx_busy;
        w[5:4]   = fault_st;
        w[3]     = rx_busy;
        w[2:0]   = fl[2:0];
        return w;
    endfunction

    task automatic chk_all(string req, logic [4:0] fl);
        #1;
        chk(req, stat_word, expw(fl));
        chk(req, {27'd0, irq}, {27'd0, fl & int_mask});
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [31:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic cross_both(logic [7:0] tf, logic [7:0] tt, logic [7:0] rf, logic [7:0] rt);
        txc = tf; rxc = rf;
        tick(); tick();
        wr(32'h0003_0007);
        txc = tt; rxc = rt;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] vals [5];
        vals = '{8'd0, 8'd95, 8'd96, 8'd97, 8'd255};
        rst_n = 0; txc = 0; rxc = 0; sync_ok = 0; bus_off = 0; freeze = 0;
        warn_en = 1; err_bits = 0; idle_st = 0; tx_busy = 0; rx_busy = 0;
        fault_st = 0; int_evt = 0; int_mask = 5'h1F; reg_wr = 0; reg_wdata = 0;
        tick(); tick();
        rst_n = 1;
        chk_all("R12 reset state", 5'b0);

        // R2: pass-through status fields
        for (int i = 0; i < 256; i++) begin
            err_bits = i[5:0]; idle_st = i[6]; tx_busy = i[7];
            rx_busy = i[0] ^ i[3]; fault_st = i[2:1]; sync_ok = i[4] ^ i[7];
            chk_all("R2 status fields", 5'b0);
        end
        wr(32'hFFFF_FFFF);
        chk("R1 reserved bits", {13'd0, stat_word[31:19]}, 32'd0);

        // R3: level compare sweep with warnings disabled
        warn_en = 0;
        for (int v = 0; v < 256; v++) begin
            txc = v[7:0]; rxc = 8'(255 - v);
            chk_all("R3 level compare", 5'b0);
            tick();
        end
        txc = 0; rxc = 0; tick();
        wr(32'h0003_0000);
        warn_en = 1;
        chk_all("R6 cleared while disabled", 5'b0);

        // R4: all start/end pairs around the limit, both directions
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                cross_both(vals[a], vals[b], vals[b], vals[a]);
                chk_all("R4 crossing", {(vals[a] < 96 && vals[b] >= 96),
                                        (vals[b] < 96 && vals[a] >= 96), 3'b000});
            end
        end
        // R4: no re-set while staying above limit after clear
        cross_both(8'd10, 8'd150, 8'd10, 8'd150);
        wr(32'h0003_0000);
        tick();
        chk_all("R4 no re-set above limit", 5'b0);

        // R5: writing zeros keeps flags; writing ones clears
        cross_both(8'd0, 8'd96, 8'd0, 8'd96);
        wr(32'h0000_0000);
        chk_all("R5 zero write no effect", 5'b11000);
        wr(32'h0002_0000);
        chk_all("R5 clear tx flag only", 5'b01000);

        // R6: masking and reappearance
        warn_en = 0;
        chk_all("R6 masked while disabled", 5'b0);
        warn_en = 1;
        chk_all("R6 reappears on enable", 5'b01000);
        txc = 0; rxc = 0; tick(); wr(32'h0003_0000);
        warn_en = 0; txc = 100; rxc = 100; tick();
        warn_en = 1; tick();
        chk_all("R6 no set while disabled", 5'b0);

        // R7: bus-off blocks only transmit
        txc = 0; rxc = 0; tick(); tick();
        bus_off = 1; txc = 96; rxc = 96; tick();
        chk_all("R7 bus-off gates tx", 5'b01000);
        bus_off = 0;

        // R8: freeze blocks set and clear
        txc = 0; rxc = 0; tick(); wr(32'h0003_0000);
        freeze = 1; txc = 96; rxc = 96; tick();
        chk_all("R8 no set in freeze", 5'b0);
        freeze = 0;
        cross_both(8'd0, 8'd96, 8'd0, 8'd96);
        freeze = 1;
        wr(32'h0003_0000);
        chk_all("R8 no clear in freeze", 5'b11000);
        freeze = 0;
        wr(32'h0003_0000);
        chk_all("R5 clear after freeze", 5'b0);

        // R9: event pulses, one at a time
        for (int k = 0; k < 3; k++) begin
            int_evt = 3'(1 << k); tick(); int_evt = 0;
            chk_all("R9 event latch", 5'(1 << k));
            wr(32'(1 << k));
            chk_all("R5 event clear", 5'b0);
        end

        // R10: set beats clear
        int_evt = 3'b111; reg_wr = 1; reg_wdata = 32'h7; tick();
        int_evt = 0; reg_wr = 0; reg_wdata = 0;
        chk_all("R10 event set wins", 5'b00111);
        txc = 95; rxc = 95; tick(); tick();
        txc = 96; rxc = 96; wr(32'h0003_0000);
        chk_all("R10 warning set wins", 5'b11111);

        // R11: every mask pattern
        for (int m = 0; m < 32; m++) begin
            int_mask = m[4:0];
            chk_all("R11 mask", 5'b11111);
        end
        int_mask = 5'h1F;

        // R12: reset mid-run
        txc = 0; rxc = 0;
        rst_n = 0; tick();
        chk_all("R12 reset clears flags", 5'b0);
        rst_n = 1; tick();
        chk_all("R12 after reset", 5'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule